// File: doc/BRIEF.md
# Write Protection and Status Controller

This block sits beside the serial command decoder of a small nonvolatile memory. It decides whether each nonvolatile write may go ahead and times that write. The decoder passes it finished events: enable and disable commands, each data byte of a status write, the completion of a full sector data phase with its sector address, and the level of chip select. The block keeps the program-enable latch and the three-bit block-lock code. It also watches the active-low write-protect pin. When chip select rises on a write it accepts, it starts a self-timed busy window of a parameterised length.

A sector write that is accepted produces a single-cycle commit strobe toward the array, carrying the sector address. An accepted status write updates the lock code when the busy window ends. The block also produces the bit stream for a read-status command. A pointer starts at the top bit and steps down on each shift pulse. The output is forced high while a write is in progress and shows the stored status bit once the write is done.

Top module: `prog_guard_ctrl`

## Requirements
- R1: After reset, busy, the enable latch, the status byte, the commit strobe and the read-status bit are all 0.
- R2: An enable event sets the enable latch (prog_en_o = 1); a disable event clears it.
- R3: The status byte holds the lock code in bits [2:0]; bits [7:3] always read 0, whatever was written to them.
- R4: A sector write is refused when its address lies in the range given by the lock code: 0 none; 1 0x000–0x0FF; 2 0x100–0x1FF; 3 0x200–0x2FF; 4 0x300–0x3FF; 5 0x000–0x1FF; 6 0x000–0x00F; 7 0x3F0–0x3FF. Addresses outside that range are accepted.
- R5: An accepted sector write raises commit_o for exactly one cycle, in the cycle after the one in which chip select is seen high, with commit_addr_o equal to the sector address. busy_o rises in the same cycle.
- R6: With the enable latch clear, neither a status write nor a sector write starts (no commit, no busy, status unchanged).
- R7: If the write-protect input is low when chip select rises, the pending write is refused.
- R8: A falling edge of the write-protect input while chip select is low cancels the pending write, even if the input returns high before chip select rises.
- R9: Once the busy window has started, the write-protect input has no effect on it: the window runs its full length and the status update still happens.
- R10: busy_o stays high for exactly WR_CYCLES clock cycles. Status bytes, sector completions and chip-select rises that arrive while busy start nothing, either then or later.
- R11: When the busy window ends, the enable latch is cleared, for status writes and sector writes alike. A status write changes status_o only at that point.
- R12: In a status write with several data bytes, the last byte received decides the code. A chip-select rise with no data byte or sector completion in the frame starts nothing.
- R13: A restart pulse points the read-status output at bit 7. Each shift pulse moves it one bit lower, wrapping from bit 0 back to bit 7. While busy the output is 1; afterwards it shows the stored bit at the current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select level, low while a frame is active |
| wp_ok_i | input | 1 | Write-protect input, low refuses and cancels writes |
| en_cmd_i | input | 1 | One-cycle pulse: enable command decoded |
| dis_cmd_i | input | 1 | One-cycle pulse: disable command decoded |
| stat_byte_vld_i | input | 1 | One-cycle pulse: a status-write data byte is complete |
| stat_byte_i | input | 8 | The status-write data byte |
| sect_done_i | input | 1 | One-cycle pulse: last bit of the sector data phase received |
| sect_addr_i | input | ADDR_W | Byte address of the sector being written |
| rs_restart_i | input | 1 | One-cycle pulse: a read-status command begins |
| rs_shift_i | input | 1 | One-cycle pulse: advance the read-status pointer |
| busy_o | output | 1 | Self-timed write in progress |
| prog_en_o | output | 1 | Enable latch state |
| status_o | output | 8 | Status byte, lock code in [2:0] |
| commit_o | output | 1 | One-cycle strobe: array may write the sector |
| commit_addr_o | output | ADDR_W | Sector address that goes with commit_o |
| rs_bit_o | output | 1 | Current read-status output bit |

## Verification
The bench builds the block with a 10-bit address, 16-byte sectors and WR_CYCLES set to 24. A short window lets it run every lock code against ten sector addresses, including the edges of each quadrant and the first and last sector. The same window is long enough for the bench to send an enable, a sector frame and a status frame while busy, and to step the read-status pointer six places. This brings the ignore-while-busy rule and the read-out at the pointer position where the window ends within reach. The default window length is only a counter limit, so it costs nothing at elaboration.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int LOCK_W = 3;

  typedef enum logic [1:0] {
    PK_NONE   = 2'd0,
    PK_STATUS = 2'd1,
    PK_SECTOR = 2'd2
  } pend_e;

  typedef enum logic [LOCK_W-1:0] {
    LK_OFF      = 3'd0,
    LK_QUAD0    = 3'd1,
    LK_QUAD1    = 3'd2,
    LK_QUAD2    = 3'd3,
    LK_QUAD3    = 3'd4,
    LK_LOWHALF  = 3'd5,
    LK_FIRSTSEC = 3'd6,
    LK_LASTSEC  = 3'd7
  } lock_e;
endpackage

// File: rtl/guard_lock_decode.sv
module guard_lock_decode
  import guard_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 4
) (
  input  lock_e             code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int SIDX_W = ADDR_W - SECT_W;

  logic [1:0]        quad;
  logic [SIDX_W-1:0] sidx;

  assign quad = addr[ADDR_W-1 -: 2];
  assign sidx = addr[ADDR_W-1:SECT_W];

  always_comb begin
    case (code)
      LK_QUAD0:    hit = (quad == 2'd0);
      LK_QUAD1:    hit = (quad == 2'd1);
      LK_QUAD2:    hit = (quad == 2'd2);
      LK_QUAD3:    hit = (quad == 2'd3);
      LK_LOWHALF:  hit = ~addr[ADDR_W-1];
      LK_FIRSTSEC: hit = (sidx == '0);
      LK_LASTSEC:  hit = (sidx == '1);
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/guard_wr_timer.sv
module guard_wr_timer #(
  parameter int WR_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start) begin
      cnt_q  <= CNT_W'(WR_CYCLES - 1);
      busy_q <= 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/guard_stat_ptr.sv
module guard_stat_ptr #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              shift,
  input  logic              busy,
  input  logic [BYTE_W-1:0] stat,
  output logic              bit_o
);
  localparam int PTR_W = $clog2(BYTE_W);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(BYTE_W - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= TOP;
    else if (restart) ptr_q <= TOP;
    else if (shift)   ptr_q <= (ptr_q == '0) ? TOP : ptr_q - 1'b1;
  end

  assign bit_o = busy | stat[ptr_q];
endmodule

// File: rtl/prog_guard_ctrl.sv
module prog_guard_ctrl
  import guard_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int SECT_W    = 4,
  parameter int WR_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              wp_ok_i,
  input  logic              en_cmd_i,
  input  logic              dis_cmd_i,
  input  logic              stat_byte_vld_i,
  input  logic [7:0]        stat_byte_i,
  input  logic              sect_done_i,
  input  logic [ADDR_W-1:0] sect_addr_i,
  input  logic              rs_restart_i,
  input  logic              rs_shift_i,
  output logic              busy_o,
  output logic              prog_en_o,
  output logic [7:0]        status_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic              rs_bit_o
);
  localparam int BYTE_W = 8;
  localparam int PAD_W  = BYTE_W - LOCK_W;

  logic              cs_q, wp_q, latch_q, commit_q;
  pend_e             pend_q, kind_q;
  lock_e             lock_q, hold_q;
  logic [ADDR_W-1:0] paddr_q, caddr_q;
  logic              cs_rise, wp_fall, hit, busy, done, grant;

  assign cs_rise = cs_n_i & ~cs_q;
  assign wp_fall = wp_q & ~wp_ok_i & ~cs_n_i;
  assign grant   = cs_rise && (pend_q != PK_NONE) && latch_q && wp_ok_i && !busy
                   && !((pend_q == PK_SECTOR) && hit);

  guard_lock_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_decode (
    .code (lock_q),
    .addr (paddr_q),
    .hit  (hit)
  );

  guard_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (grant),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      wp_q     <= 1'b1;
      latch_q  <= 1'b0;
      commit_q <= 1'b0;
      pend_q   <= PK_NONE;
      kind_q   <= PK_NONE;
      lock_q   <= LK_OFF;
      hold_q   <= LK_OFF;
      paddr_q  <= '0;
      caddr_q  <= '0;
    end else begin
      cs_q     <= cs_n_i;
      wp_q     <= wp_ok_i;
      commit_q <= 1'b0;

      if (cs_rise) begin
        pend_q <= PK_NONE;
        if (grant) begin
          kind_q   <= pend_q;
          commit_q <= (pend_q == PK_SECTOR);
          caddr_q  <= paddr_q;
        end
      end else if (wp_fall) begin
        pend_q <= PK_NONE;
      end else if (!busy && !cs_n_i) begin
        if (stat_byte_vld_i) begin
          pend_q <= PK_STATUS;
          hold_q <= lock_e'(stat_byte_i[LOCK_W-1:0]);
        end else if (sect_done_i) begin
          pend_q  <= PK_SECTOR;
          paddr_q <= sect_addr_i;
        end
      end

      if (done) begin
        if (kind_q == PK_STATUS) lock_q <= hold_q;
        kind_q <= PK_NONE;
      end

      if (dis_cmd_i)     latch_q <= 1'b0;
      else if (en_cmd_i) latch_q <= 1'b1;
      else if (done)     latch_q <= 1'b0;
    end
  end

  assign status_o      = {{PAD_W{1'b0}}, lock_q};
  assign busy_o        = busy;
  assign prog_en_o     = latch_q;
  assign commit_o      = commit_q;
  assign commit_addr_o = caddr_q;

  guard_stat_ptr #(.BYTE_W(BYTE_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .restart (rs_restart_i),
    .shift   (rs_shift_i),
    .busy    (busy),
    .stat    (status_o),
    .bit_o   (rs_bit_o)
  );
endmodule

// File: rtl/prog_guard_chk.sv
module prog_guard_chk #(
  parameter int WR_CYCLES = 50000
) (
  input logic       clk,
  input logic       rst,
  input logic       wp_ok_i,
  input logic       busy_o,
  input logic       prog_en_o,
  input logic [7:0] status_o,
  input logic       commit_o,
  input logic       rs_bit_o
);
  int run_q;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    status_o[7:3] == 5'd0);

  p_commit_single_r5: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  p_commit_busy_r5: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> busy_o);

  p_commit_latch_r6: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(prog_en_o));

  p_commit_pin_r7: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(wp_ok_i));

  p_busy_len_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_q == WR_CYCLES));

  p_busy_cap_r10: assert property (@(posedge clk) disable iff (rst)
    run_q <= WR_CYCLES);

  p_status_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(status_o));

  p_busy_high_r13: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> rs_bit_o);
endmodule

bind prog_guard_ctrl prog_guard_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wp_ok_i   (wp_ok_i),
  .busy_o    (busy_o),
  .prog_en_o (prog_en_o),
  .status_o  (status_o),
  .commit_o  (commit_o),
  .rs_bit_o  (rs_bit_o)
);

// File: tb/test_prog_guard_ctrl.sv
module test_prog_guard_ctrl;
  localparam int AW = 10;
  localparam int SW = 4;
  localparam int WC = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, cs_n = 1'b1, wp_ok = 1'b1, en = 1'b0, dis = 1'b0;
  logic          sbv = 1'b0, sdone = 1'b0, rsr = 1'b0, rss = 1'b0;
  logic [7:0]    sbyte = '0;
  logic [AW-1:0] saddr = '0;
  logic          busy_o, prog_en_o, commit_o, rs_bit_o;
  logic [7:0]    status_o;
  logic [AW-1:0] commit_addr_o;

  int n_chk = 0, n_bad = 0, commits = 0;

  prog_guard_ctrl #(.ADDR_W(AW), .SECT_W(SW), .WR_CYCLES(WC)) i_prog_guard_ctrl (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .wp_ok_i(wp_ok), .en_cmd_i(en), .dis_cmd_i(dis),
    .stat_byte_vld_i(sbv), .stat_byte_i(sbyte), .sect_done_i(sdone), .sect_addr_i(saddr),
    .rs_restart_i(rsr), .rs_shift_i(rss), .busy_o(busy_o), .prog_en_o(prog_en_o),
    .status_o(status_o), .commit_o(commit_o), .commit_addr_o(commit_addr_o),
    .rs_bit_o(rs_bit_o)
  );

  always @(negedge clk) if (!rst && commit_o) commits++;

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic bit prot(input int code, input int a);
    case (code)
      1: return a <= 'h0FF;
      2: return a >= 'h100 && a <= 'h1FF;
      3: return a >= 'h200 && a <= 'h2FF;
      4: return a >= 'h300;
      5: return a <= 'h1FF;
      6: return a <= 'h00F;
      7: return a >= 'h3F0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_enable();
    cs_n = 0; tick(); en = 1; tick(); en = 0; cs_n = 1; tick();
  endtask

  task automatic do_disable();
    cs_n = 0; tick(); dis = 1; tick(); dis = 0; cs_n = 1; tick();
  endtask

  task automatic stat_frame(input logic [7:0] b);
    cs_n = 0; tick(); sbv = 1; sbyte = b; tick(); sbv = 0; cs_n = 1; tick();
  endtask

  task automatic sect_frame(input logic [AW-1:0] a);
    cs_n = 0; tick(); sdone = 1; saddr = a; tick(); sdone = 0; cs_n = 1; tick();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin n++; tick(); end
  endtask

  task automatic set_status(input logic [7:0] b);
    int n;
    do_enable(); stat_frame(b); wait_idle(n);
  endtask

  task automatic t_reset();
    check("R1", "busy", busy_o, 0);
    check("R1", "latch", prog_en_o, 0);
    check("R1", "status", status_o, 0);
    check("R1", "commit", commit_o, 0);
    check("R1", "rs_bit", rs_bit_o, 0);
  endtask

  task automatic t_latch();
    do_enable();  check("R2", "latch after enable", prog_en_o, 1);
    do_disable(); check("R2", "latch after disable", prog_en_o, 0);
  endtask

  task automatic t_fields();
    int n;
    do_enable(); stat_frame(8'hFD);
    check("R11", "status unchanged at start", status_o, 0);
    wait_idle(n);
    check("R3", "upper bits masked", status_o, 8'h05);
    check("R11", "latch cleared after status write", prog_en_o, 0);
    rsr = 1; tick(); rsr = 0;
    for (int i = 0; i < 16; i++) begin
      check("R13", $sformatf("stream bit %0d", i), rs_bit_o, 32'(status_o[(7 - i) & 7]));
      rss = 1; tick(); rss = 0;
    end
  endtask

  task automatic t_decode();
    int n;
    int addrs[10] = '{'h000, 'h010, 'h0F0, 'h100, 'h1F0, 'h200, 'h2F0, 'h300, 'h3E0, 'h3F0};
    for (int code = 0; code < 8; code++) begin
      set_status(8'(code));
      foreach (addrs[k]) begin
        bit ok;
        ok = !prot(code, addrs[k]);
        do_enable();
        cs_n = 0; tick(); sdone = 1; saddr = AW'(addrs[k]); tick(); sdone = 0; cs_n = 1; tick();
        check("R4", $sformatf("commit code %0d addr %0h", code, addrs[k]), commit_o, ok);
        check("R5", "busy with commit", busy_o, ok);
        if (ok) check("R5", "commit address", commit_addr_o, addrs[k]);
        tick();
        check("R5", "strobe one cycle", commit_o, 0);
        if (ok) begin
          wait_idle(n);
          check("R10", "busy length", n + 1, WC);
          check("R11", "latch cleared after sector", prog_en_o, 0);
        end else do_disable();
      end
    end
  endtask

  task automatic t_multi();
    int n;
    do_enable();
    cs_n = 0; tick();
    sbv = 1; sbyte = 8'h03; tick(); sbyte = 8'h06; tick(); sbyte = 8'h02; tick();
    sbv = 0; cs_n = 1; tick();
    wait_idle(n);
    check("R12", "last byte wins", status_o, 2);
    do_enable();
    cs_n = 0; tick(); cs_n = 1; tick(); tick();
    check("R12", "empty frame no busy", busy_o, 0);
    do_disable();
  endtask

  task automatic t_no_latch();
    int c0 = commits;
    stat_frame(8'h01); tick();
    check("R6", "no busy without latch", busy_o, 0);
    check("R6", "status unchanged", status_o, 2);
    sect_frame(10'h240); tick();
    check("R6", "no commit without latch", commits - c0, 0);
  endtask

  task automatic t_pin_low();
    int n;
    int c0 = commits;
    do_enable();
    cs_n = 0; tick(); sdone = 1; saddr = 10'h040; tick(); sdone = 0; wp_ok = 0; tick();
    cs_n = 1; tick(); tick();
    check("R7", "refused with pin low", commits - c0, 0);
    check("R7", "no busy with pin low", busy_o, 0);
    wp_ok = 1; tick();
    sect_frame(10'h040);
    check("R7", "accepted with pin high", commit_o, 1);
    wait_idle(n);
  endtask

  task automatic t_pin_glitch();
    int c0 = commits;
    do_enable();
    cs_n = 0; tick(); sdone = 1; saddr = 10'h080; tick(); sdone = 0;
    wp_ok = 0; tick(); wp_ok = 1; tick();
    cs_n = 1; tick(); tick();
    check("R8", "pin fall cancels", commits - c0, 0);
    check("R8", "no busy after cancel", busy_o, 0);
    do_disable();
  endtask

  task automatic t_pin_busy();
    int n;
    do_enable(); stat_frame(8'h03);
    wp_ok = 0;
    wait_idle(n);
    check("R9", "busy runs full", n, WC);
    check("R9", "status written", status_o, 3);
    wp_ok = 1; tick();
  endtask

  task automatic t_busy_ignore();
    int n;
    int c0 = commits;
    do_enable(); stat_frame(8'h04);
    do_enable(); sect_frame(10'h100); stat_frame(8'h07);
    check("R10", "still busy", busy_o, 1);
    wait_idle(n); tick(); tick();
    check("R10", "no commit from busy frames", commits - c0, 0);
    check("R10", "no later start", busy_o, 0);
    check("R10", "status from granted write", status_o, 4);
    check("R11", "latch cleared at end", prog_en_o, 0);
  endtask

  task automatic t_rs_busy();
    int n;
    do_enable(); stat_frame(8'h05);
    rsr = 1; tick(); rsr = 0;
    check("R13", "high while busy at bit7", rs_bit_o, 1);
    for (int i = 0; i < 6; i++) begin
      rss = 1; tick(); rss = 0;
      check("R13", "high while busy", rs_bit_o, 1);
    end
    wait_idle(n);
    check("R13", "bit1 after busy", rs_bit_o, 0);
    rss = 1; tick(); rss = 0;
    check("R13", "bit0 after busy", rs_bit_o, 1);
    rss = 1; tick(); rss = 0;
    check("R13", "wrap to bit7", rs_bit_o, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    t_reset();
    t_latch();
    t_fields();
    t_decode();
    t_multi();
    t_no_latch();
    t_pin_low();
    t_pin_glitch();
    t_pin_busy();
    t_busy_ignore();
    t_rs_busy();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule